// File: doc/BRIEF.md
# Packed-Lane Multiplier with Dot-Product Accumulate

This block is the multiply unit of a small signal-processing core. A single request carries two 32-bit operands, a 32-bit accumulator operand, an operation select, a lane mode, a sign control and a shift amount. The same operand pair can be treated as one word, two halfwords or four bytes. The block then forms lane-wise products, a dot product across the lanes added to the accumulator, or a fixed-point product scaled down by a chosen number of fraction bits.

Work is split across four sub-units: a lane multiplier, a halfword dot-product unit, a byte dot-product unit and a fractional unit. Each sub-unit owns its operand register. A sub-unit that is not addressed in a cycle loads zeros, so idle arithmetic does not toggle. The result comes out of one registered stage. `out_valid` rises in the cycle after a request is accepted and carries the result with it.

Encodings are as follows. `op_sel` is 0 for lane multiply, 1 for dot product, 2 for fractional, and 3 behaves like 0. `lane_mode` is 0 for bytes, 1 for halfwords, and 2 or 3 for a word.

Top module: `simd_dotmul`

## Requirements
- R1: In lane multiply with `lane_mode`=0, each result byte i (bits 8i+7..8i) is the low 8 bits of A byte i times B byte i. The result wraps and does not depend on `is_signed`.
- R2: In lane multiply with `lane_mode`=1, each result halfword is the low 16 bits of the product of the matching operand halfwords.
- R3: In lane multiply with `lane_mode`=2 or 3, the result is the low 32 bits of A times B.
- R4: A dot product with `lane_mode`=1 returns C + A[31:16]*B[31:16] + A[15:0]*B[15:0], modulo 2^32. Each lane is sign-extended when `is_signed`=1 and zero-extended otherwise.
- R5: A dot product with `lane_mode`=0 returns C plus the sum of the four byte-lane products, modulo 2^32, with the lanes extended as in R4.
- R6: A dot product with `lane_mode`=2 or 3 returns the low 32 bits of A*B + C.
- R7: The fractional operation forms the full product of A and B, signed when `is_signed`=1 and unsigned otherwise. It shifts that product right by `frac_shift` (0..31), arithmetically when signed, and returns the low 32 bits. `lane_mode` has no effect on it.
- R8: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high, and low after a cycle with `in_valid` low.
- R9: `out_result` is zero in every cycle where `out_valid` is low.
- R10: While `rst_n` is low and in the first cycle after it, `out_valid` and `out_result` are zero.
- R11: A sub-unit that is not addressed loads zero operands. Back-to-back requests to different sub-units each return their own correct result, with no carry-over from the previous request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request accepted this cycle |
| op_a | input | 32 | Operand A |
| op_b | input | 32 | Operand B |
| op_c | input | 32 | Accumulator operand |
| op_sel | input | 2 | 0 lane multiply, 1 dot product, 2 fractional, 3 as 0 |
| lane_mode | input | 2 | 0 bytes, 1 halfwords, 2/3 word |
| is_signed | input | 1 | Signed lane extension for dot and fractional |
| frac_shift | input | 5 | Right shift applied to the fractional product |
| out_valid | output | 1 | Result present |
| out_result | output | 32 | Result, zero when not valid |

## Verification
The bench builds the block at its default 32-bit width. At that width there are four byte lanes, two halfword lanes and 5-bit shift amounts, so every lane mode and shift from 0 to 31 can be reached. Directed cases exercise byte and halfword wrap, all-ones unsigned and most-negative signed dot lanes, Q3.12 scaling and the extreme shifts. A seeded random stream then mixes every operation, mode and sign back to back, with idle gaps in between. This exposes leakage between sub-units and checks the one-cycle timing.

// File: rtl/smul_pkg.sv
package smul_pkg;
    typedef enum logic [1:0] {
        OP_LANE = 2'd0,
        OP_DOT  = 2'd1,
        OP_FRAC = 2'd2,
        OP_ALT  = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        LM_BYTE  = 2'd0,
        LM_HALF  = 2'd1,
        LM_WORD  = 2'd2,
        LM_WORDX = 2'd3
    } lane_e;

    typedef enum logic [1:0] {
        RT_LANE = 2'd0,
        RT_D16  = 2'd1,
        RT_D8   = 2'd2,
        RT_FRAC = 2'd3
    } route_e;
endpackage

// File: rtl/smul_lane_unit.sv
module smul_lane_unit #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              acc_en,
    input  logic [1:0]        mode,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic [DATA_W-1:0] c,
    output logic [DATA_W-1:0] y
);
    localparam int BL = DATA_W / 8;
    localparam int HL = DATA_W / 16;

    typedef struct packed {
        logic              acc;
        logic [1:0]        mode;
        logic [DATA_W-1:0] a;
        logic [DATA_W-1:0] b;
        logic [DATA_W-1:0] c;
    } lane_st_t;

    lane_st_t st_d, st_q;

    always_comb begin
        st_d = '0;
        if (load) begin
            st_d.acc  = acc_en;
            st_d.mode = mode;
            st_d.a    = a;
            st_d.b    = b;
            st_d.c    = c;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    logic [DATA_W-1:0] y_byte, y_half, y_word, y_base;

    for (genvar g = 0; g < BL; g++) begin : g_byte
        assign y_byte[g*8 +: 8] = st_q.a[g*8 +: 8] * st_q.b[g*8 +: 8];
    end
    for (genvar g = 0; g < HL; g++) begin : g_half
        assign y_half[g*16 +: 16] = st_q.a[g*16 +: 16] * st_q.b[g*16 +: 16];
    end
    assign y_word = st_q.a * st_q.b;

    always_comb begin
        unique case (st_q.mode)
            2'd0:    y_base = y_byte;
            2'd1:    y_base = y_half;
            default: y_base = y_word;
        endcase
        y = st_q.acc ? (y_base + st_q.c) : y_base;
    end

    AST_LANE_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> (y == '0)); // R11
endmodule

// File: rtl/smul_dot_unit.sv
module smul_dot_unit #(
    parameter int DATA_W = 32,
    parameter int LANE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              sgn,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic [DATA_W-1:0] c,
    output logic [DATA_W-1:0] y
);
    localparam int LANES = DATA_W / LANE_W;
    localparam int PW    = 2 * LANE_W + 2;
    localparam int EW    = 2 * DATA_W;

    typedef struct packed {
        logic              sgn;
        logic [DATA_W-1:0] a;
        logic [DATA_W-1:0] b;
        logic [DATA_W-1:0] c;
    } dot_st_t;

    dot_st_t st_d, st_q;

    always_comb begin
        st_d = '0;
        if (load) begin
            st_d.sgn = sgn;
            st_d.a   = a;
            st_d.b   = b;
            st_d.c   = c;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    logic signed [LANE_W:0] ea, eb;
    logic signed [PW-1:0]   p;
    logic        [EW-1:0]   pe;
    logic        [DATA_W-1:0] sum;

    always_comb begin
        sum = st_q.c;
        ea  = '0;
        eb  = '0;
        p   = '0;
        pe  = '0;
        for (int i = 0; i < LANES; i++) begin
            ea  = $signed({st_q.sgn & st_q.a[i*LANE_W+LANE_W-1], st_q.a[i*LANE_W +: LANE_W]});
            eb  = $signed({st_q.sgn & st_q.b[i*LANE_W+LANE_W-1], st_q.b[i*LANE_W +: LANE_W]});
            p   = ea * eb;
            pe  = {{(EW-PW){p[PW-1]}}, p};
            sum = sum + pe[DATA_W-1:0];
        end
        y = sum;
    end

    AST_DOT_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> (y == '0)); // R11
endmodule

// File: rtl/smul_frac_unit.sv
module smul_frac_unit #(
    parameter int DATA_W = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      load,
    input  logic                      sgn,
    input  logic [$clog2(DATA_W)-1:0] sh,
    input  logic [DATA_W-1:0]         a,
    input  logic [DATA_W-1:0]         b,
    output logic [DATA_W-1:0]         y
);
    localparam int SH_W = $clog2(DATA_W);
    localparam int PW   = 2 * DATA_W + 2;

    typedef struct packed {
        logic              sgn;
        logic [SH_W-1:0]   sh;
        logic [DATA_W-1:0] a;
        logic [DATA_W-1:0] b;
    } frac_st_t;

    frac_st_t st_d, st_q;

    always_comb begin
        st_d = '0;
        if (load) begin
            st_d.sgn = sgn;
            st_d.sh  = sh;
            st_d.a   = a;
            st_d.b   = b;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    logic signed [DATA_W:0] ea, eb;
    logic signed [PW-1:0]   prod, shd;

    always_comb begin
        ea   = $signed({st_q.sgn & st_q.a[DATA_W-1], st_q.a});
        eb   = $signed({st_q.sgn & st_q.b[DATA_W-1], st_q.b});
        prod = ea * eb;
        shd  = prod >>> st_q.sh;
        y    = shd[DATA_W-1:0];
    end

    AST_FRAC_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> (y == '0)); // R11
endmodule

// File: rtl/simd_dotmul.sv
module simd_dotmul #(
    parameter int DATA_W = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic [DATA_W-1:0]         op_a,
    input  logic [DATA_W-1:0]         op_b,
    input  logic [DATA_W-1:0]         op_c,
    input  logic [1:0]                op_sel,
    input  logic [1:0]                lane_mode,
    input  logic                      is_signed,
    input  logic [$clog2(DATA_W)-1:0] frac_shift,
    output logic                      out_valid,
    output logic [DATA_W-1:0]         out_result
);
    import smul_pkg::*;

    typedef struct packed {
        logic   valid;
        route_e route;
    } ctl_t;

    ctl_t  ctl_d, ctl_q;
    op_e   op;
    lane_e lm;
    logic  word_mode;
    logic  ld_lane, ld_d16, ld_d8, ld_frac;
    logic [DATA_W-1:0] y_lane, y_d16, y_d8, y_frac;

    assign op        = op_e'(op_sel);
    assign lm        = lane_e'(lane_mode);
    assign word_mode = (lm == LM_WORD) || (lm == LM_WORDX);

    always_comb begin
        ld_lane = 1'b0;
        ld_d16  = 1'b0;
        ld_d8   = 1'b0;
        ld_frac = 1'b0;
        ctl_d   = '{valid: in_valid, route: RT_LANE};
        if (in_valid) begin
            unique case (op)
                OP_DOT: begin
                    if (lm == LM_HALF) begin
                        ld_d16      = 1'b1;
                        ctl_d.route = RT_D16;
                    end else if (lm == LM_BYTE) begin
                        ld_d8       = 1'b1;
                        ctl_d.route = RT_D8;
                    end else begin
                        ld_lane     = 1'b1;
                    end
                end
                OP_FRAC: begin
                    ld_frac     = 1'b1;
                    ctl_d.route = RT_FRAC;
                end
                default: ld_lane = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '{valid: 1'b0, route: RT_LANE};
        else        ctl_q <= ctl_d;
    end

    smul_lane_unit #(.DATA_W(DATA_W)) u_lane (
        .clk(clk), .rst_n(rst_n), .load(ld_lane),
        .acc_en((op == OP_DOT) && word_mode), .mode(lane_mode),
        .a(op_a), .b(op_b), .c(op_c), .y(y_lane)
    );

    smul_dot_unit #(.DATA_W(DATA_W), .LANE_W(16)) u_dot16 (
        .clk(clk), .rst_n(rst_n), .load(ld_d16), .sgn(is_signed),
        .a(op_a), .b(op_b), .c(op_c), .y(y_d16)
    );

    smul_dot_unit #(.DATA_W(DATA_W), .LANE_W(8)) u_dot8 (
        .clk(clk), .rst_n(rst_n), .load(ld_d8), .sgn(is_signed),
        .a(op_a), .b(op_b), .c(op_c), .y(y_d8)
    );

    smul_frac_unit #(.DATA_W(DATA_W)) u_frac (
        .clk(clk), .rst_n(rst_n), .load(ld_frac), .sgn(is_signed),
        .sh(frac_shift), .a(op_a), .b(op_b), .y(y_frac)
    );

    always_comb begin
        out_valid  = ctl_q.valid;
        out_result = '0;
        if (ctl_q.valid) begin
            unique case (ctl_q.route)
                RT_D16:  out_result = y_d16;
                RT_D8:   out_result = y_d8;
                RT_FRAC: out_result = y_frac;
                default: out_result = y_lane;
            endcase
        end
    end

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R8
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R8
endmodule

// File: tb/tb_simd_dotmul.sv
`timescale 1ns/1ps
module tb_simd_dotmul;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [31:0] op_a, op_b, op_c;
    logic [1:0]  op_sel, lane_mode;
    logic        is_signed;
    logic [4:0]  frac_shift;
    logic        out_valid;
    logic [31:0] out_result;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    simd_dotmul dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .op_a(op_a), .op_b(op_b), .op_c(op_c),
        .op_sel(op_sel), .lane_mode(lane_mode), .is_signed(is_signed),
        .frac_shift(frac_shift), .out_valid(out_valid), .out_result(out_result)
    );

    function automatic longint lane_val(input logic [31:0] v, input int pos, input int w, input bit s);
        longint x;
        x = longint'((v >> pos) & ((32'd1 << w) - 32'd1));
        if (s && x[w-1]) x = x - (longint'(1) << w);
        return x;
    endfunction

    function automatic logic [31:0] model(input logic [31:0] a, input logic [31:0] b,
                                          input logic [31:0] c, input logic [1:0] op,
                                          input logic [1:0] md, input bit s, input logic [4:0] sh);
        logic [31:0] r;
        longint acc;
        longint pa, pb;
        logic [63:0] up;
        r = 32'd0;
        if (op == 2'd2) begin
            if (s) begin
                pa = longint'($signed(a));
                pb = longint'($signed(b));
                acc = (pa * pb) >>> sh;
                r = acc[31:0];
            end else begin
                up = ({32'd0, a} * {32'd0, b}) >> sh;
                r = up[31:0];
            end
        end else if (op == 2'd1 && md == 2'd1) begin
            acc = longint'(c);
            for (int i = 0; i < 2; i++)
                acc += lane_val(a, 16*i, 16, s) * lane_val(b, 16*i, 16, s);
            r = acc[31:0];
        end else if (op == 2'd1 && md == 2'd0) begin
            acc = longint'(c);
            for (int i = 0; i < 4; i++)
                acc += lane_val(a, 8*i, 8, s) * lane_val(b, 8*i, 8, s);
            r = acc[31:0];
        end else if (op == 2'd1) begin
            r = a * b + c;
        end else if (md == 2'd0) begin
            for (int i = 0; i < 4; i++) begin
                acc = lane_val(a, 8*i, 8, 0) * lane_val(b, 8*i, 8, 0);
                r[8*i +: 8] = acc[7:0];
            end
        end else if (md == 2'd1) begin
            for (int i = 0; i < 2; i++) begin
                acc = lane_val(a, 16*i, 16, 0) * lane_val(b, 16*i, 16, 0);
                r[16*i +: 16] = acc[15:0];
            end
        end else begin
            r = a * b;
        end
        return r;
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s: actual=%08h expected=%08h", tag, got, exp);
        end
    endtask

    task automatic run_op(input string tag, input logic [31:0] a, input logic [31:0] b,
                          input logic [31:0] c, input logic [1:0] op, input logic [1:0] md,
                          input bit s, input logic [4:0] sh);
        logic [31:0] exp;
        exp = model(a, b, c, op, md, s, sh);
        in_valid = 1'b1; op_a = a; op_b = b; op_c = c;
        op_sel = op; lane_mode = md; is_signed = s; frac_shift = sh;
        @(negedge clk);
        check({tag, " R8 valid"}, {31'd0, out_valid}, 32'd1);
        check(tag, out_result, exp);
    endtask

    task automatic idle_cycle();
        in_valid = 1'b0;
        op_a = $urandom; op_b = $urandom; op_c = $urandom;
        @(negedge clk);
        check("R8 valid low after idle", {31'd0, out_valid}, 32'd0);
        check("R9 result zero when not valid", out_result, 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240517));
        rst_n = 1'b0; in_valid = 1'b0;
        op_a = '0; op_b = '0; op_c = '0; op_sel = '0; lane_mode = '0;
        is_signed = 1'b0; frac_shift = '0;
        repeat (3) @(negedge clk);
        in_valid = 1'b1; op_a = 32'h1234_5678; op_b = 32'h9abc_def0;
        @(negedge clk);
        check("R10 valid in reset", {31'd0, out_valid}, 32'd0);
        check("R10 result in reset", out_result, 32'd0);
        in_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 valid after reset", {31'd0, out_valid}, 32'd0);
        check("R10 result after reset", out_result, 32'd0);

        run_op("R1 byte wrap ff*ff", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 2'd0, 2'd0, 1'b1, 5'd0);
        check("R1 byte wrap literal", out_result, 32'h0101_0101);
        run_op("R1 byte lanes", 32'h10_03_80_07, 32'h10_05_02_09, 32'h0, 2'd0, 2'd0, 1'b0, 5'd0);
        run_op("R2 half wrap", 32'h8000_0003, 32'h0002_0005, 32'h0, 2'd0, 2'd1, 1'b0, 5'd0);
        check("R2 half literal", out_result, 32'h0000_000F);
        run_op("R3 word", 32'h0001_0001, 32'h0001_0001, 32'hFFFF, 2'd3, 2'd2, 1'b1, 5'd0);
        check("R3 word literal", out_result, 32'h0002_0001);
        run_op("R4 dot16 signed", 32'hFFFF_0002, 32'h0003_0004, 32'd100, 2'd1, 2'd1, 1'b1, 5'd0);
        check("R4 dot16 literal", out_result, 32'd105);
        run_op("R4 dot16 unsigned max", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'd7, 2'd1, 2'd1, 1'b0, 5'd0);
        run_op("R4 dot16 signed minneg", 32'h8000_8000, 32'h8000_8000, 32'h0, 2'd1, 2'd1, 1'b1, 5'd0);
        check("R4 minneg literal", out_result, 32'h8000_0000);
        run_op("R5 dot8 signed", 32'hFF_FF_FF_FF, 32'h01_01_01_01, 32'd10, 2'd1, 2'd0, 1'b1, 5'd0);
        check("R5 dot8 literal", out_result, 32'd6);
        run_op("R5 dot8 unsigned", 32'hFF_FF_FF_FF, 32'h01_01_01_01, 32'd10, 2'd1, 2'd0, 1'b0, 5'd0);
        check("R5 dot8 unsigned literal", out_result, 32'd1030);
        run_op("R6 word mac wrap", 32'hFFFF_FFFF, 32'h2, 32'h5, 2'd1, 2'd3, 1'b0, 5'd0);
        check("R6 literal", out_result, 32'h3);
        run_op("R7 Q3.12 product", 32'h1800, 32'h2000, 32'h0, 2'd2, 2'd0, 1'b1, 5'd12);
        check("R7 Q3.12 literal", out_result, 32'h3000);
        run_op("R7 negative Q3.12", 32'hFFFF_E800, 32'h2000, 32'h0, 2'd2, 2'd1, 1'b1, 5'd12);
        check("R7 negative literal", out_result, 32'hFFFF_D000);
        run_op("R7 shift 31 signed", 32'h8000_0000, 32'h7FFF_FFFF, 32'h0, 2'd2, 2'd2, 1'b1, 5'd31);
        run_op("R7 shift 31 unsigned", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 2'd2, 2'd0, 1'b0, 5'd31);
        run_op("R7 shift 0", 32'h1234_5678, 32'h0000_0010, 32'h0, 2'd2, 2'd3, 1'b0, 5'd0);
        idle_cycle();
        run_op("R11 dot8 then lane", 32'h0202_0202, 32'h0303_0303, 32'd1, 2'd1, 2'd0, 1'b0, 5'd0);
        run_op("R11 lane after dot8", 32'h0000_0001, 32'h0000_0001, 32'd99, 2'd0, 2'd0, 1'b0, 5'd0);
        run_op("R11 frac after lane", 32'h0000_0001, 32'h0000_0001, 32'd99, 2'd2, 2'd0, 1'b0, 5'd0);
        run_op("R11 dot16 after frac", 32'h0001_0001, 32'h0001_0001, 32'd0, 2'd1, 2'd1, 1'b0, 5'd0);
        idle_cycle();

        for (int n = 0; n < 400; n++) begin
            if (($urandom % 8) == 0) idle_cycle();
            else run_op("R11 random stream", $urandom, $urandom, $urandom,
                        2'($urandom), 2'($urandom), 1'($urandom), 5'($urandom));
        end
        idle_cycle();

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule